// File: doc/BRIEF.md
# Clock Alarm, Watchdog and Event Interrupt Unit

This unit sits beside a BCD time-of-day counter. On every 1 Hz tick it compares the current seconds, minutes, hours and date against four programmable alarm fields. Each field carries a mask bit, so the same alarm can fire on one exact moment, or once per second, minute, hour or day, depending on which of the higher fields are masked. A software-reloaded watchdog counts the same ticks and reports an expiry. A power-fail input is edge-detected.

Each of the three events (watchdog, alarm, power fail) sets a sticky flag. Reading the flag register clears all flags. An event that lands in the same cycle as that read is kept. Each flag has its own interrupt enable. The enabled flags drive one interrupt pin, whose active level and pulse-or-level behaviour are selected through a control register.

A small register port (address, write strobe, read strobe, data) configures the unit. Read data is combinational from the addressed register.

Top module: `rtc_event_irq`

## Requirements
- R1: After reset, flags_o is 0, every register reads 0, the watchdog is disabled, and irq_o is 1. Control 0 means active-low, so 1 is the inactive level.
- R2: Alarm fields sit at addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (date). Each has bit 7 = mask and bits 6:0 = BCD value. On a cycle with tick_i high, the alarm flag (flags bit 1) is set when every field is either masked or equal to bits 6:0 of its time input.
- R3: Flags read at address 6 as bit 0 = watchdog, bit 1 = alarm, bit 2 = power fail. A read strobe to address 6 clears every flag at that clock edge.
- R4: An event occurring in the same cycle as a flag read leaves its flag set after the read.
- R5: A write of N to address 5 loads the watchdog reload value and restarts the count. On the Nth following tick with no new write, wdt_timeout_o is high during that tick cycle, flags bit 0 is set, and the count re-arms to N. N = 0 disables the watchdog.
- R6: Flags bit 2 is set on a rising edge of pwr_fail_i only. A level held high does not set it again after a clear.
- R7: The control register is at address 4. Bits 2:0 are the interrupt enables, aligned with the flag bits. A set flag whose enable is 0 leaves irq_o inactive.
- R8: Control bit 3 selects polarity: 1 means irq_o is high when active, 0 means low when active.
- R9: With control bit 4 = 1 (pulse mode), an event that sets an enabled flag makes irq_o active for exactly PULSE_LEN cycles, starting the cycle after the event.
- R10: With control bit 4 = 0 (level mode), irq_o stays active while any enabled flag is set, until a flag read clears the flags.
- R11: The alarm, control and watchdog registers read back the value written. Control keeps bits 4:0; watchdog keeps WDT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| tick_i | input | 1 | One-cycle 1 Hz strobe |
| pwr_fail_i | input | 1 | Power-fail indication, level |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of addressed register |
| flags_o | output | 3 | Flags: power fail, alarm, watchdog |
| irq_o | output | 1 | Interrupt pin |
| wdt_timeout_o | output | 1 | Watchdog expiry strobe |

## Verification
A wrong mask or comparison term in the alarm path appears on flags_o bit 1 one clock after the tick that should or should not have matched. The bench sweeps every mask pattern against every pattern of field agreement to expose it. A stale or mis-reloaded watchdog count shows as a timeout strobe on the wrong tick, several seconds of ticks later. A flag-clear priority error is visible on the cycle after a flag read. A pulse-counter error is visible as a wrong count of active irq_o cycles within a few clocks of the event.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int N_FLAGS = 3;
  localparam int N_FLD   = 4;
  localparam int FLD_W   = 7;

  localparam logic [ADDR_W-1:0] A_ALM_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ALM_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALM_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALM_DATE = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd4;
  localparam logic [ADDR_W-1:0] A_WDT      = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 3'd6;

  localparam int F_WD = 0;
  localparam int F_AL = 1;
  localparam int F_PF = 2;

  typedef struct packed {
    logic             mask;
    logic [FLD_W-1:0] val;
  } alm_fld_t;

  typedef struct packed {
    logic               pulse;
    logic               pol_hi;
    logic [N_FLAGS-1:0] ien;
  } ctrl_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_evt_pkg::*;
#(
  parameter int NF = N_FLD
) (
  input  logic               tick_i,
  input  alm_fld_t [NF-1:0]  alm_i,
  input  logic [NF-1:0][7:0] time_i,
  output logic               evt_o
);
  logic [NF-1:0] hit;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign hit[g] = alm_i[g].mask || (time_i[g][FLD_W-1:0] == alm_i[g].val);
  end

  assign evt_o = tick_i && (&hit);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int WDT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WDT_W-1:0] reload_i,
  output logic [WDT_W-1:0] reload_o,
  output logic             expire_o
);
  logic [WDT_W-1:0] reload_q, cnt_q;

  assign reload_o = reload_q;
  assign expire_o = tick_i && !load_i && (reload_q != '0) && (cnt_q == WDT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= reload_i;
      cnt_q    <= reload_i;
    end else if (tick_i && reload_q != '0) begin
      cnt_q <= (cnt_q <= WDT_W'(1)) ? reload_q : cnt_q - WDT_W'(1);
    end
  end

  // R5
  wdt_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import rtc_evt_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] flags_i,
  input  ctrl_t              ctrl_i,
  input  logic               trig_i,
  output logic               irq_o
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [PC_W-1:0] cnt_q;
  logic            act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= PC_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - PC_W'(1);
  end

  assign act   = ctrl_i.pulse ? (cnt_q != '0) : |(flags_i & ctrl_i.ien);
  assign irq_o = ctrl_i.pol_hi ? act : !act;

  // R9
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.pulse && cnt_q == '0 && !trig_i) |=> (!ctrl_i.pulse || !act));
endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq
  import rtc_evt_pkg::*;
#(
  parameter int WDT_W     = 6,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        date_i,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_FLAGS-1:0] flags_o,
  output logic              irq_o,
  output logic              wdt_timeout_o
);
  alm_fld_t [N_FLD-1:0]  alm_q;
  ctrl_t                 ctrl_q;
  logic [N_FLAGS-1:0]    flags_q, evt_vec;
  logic                  pf_q, al_evt, wd_evt, pf_evt, rd_clr, wdt_load;
  logic [WDT_W-1:0]      wdt_reload;
  logic [N_FLD-1:0][7:0] time_vec;

  assign time_vec = {date_i, hour_i, min_i, sec_i};
  assign rd_clr   = reg_re_i && (reg_addr_i == A_FLAGS);
  assign wdt_load = reg_we_i && (reg_addr_i == A_WDT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= '0;
      ctrl_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i < ADDR_W'(N_FLD)) alm_q[reg_addr_i[1:0]] <= alm_fld_t'(reg_wdata_i);
      if (reg_addr_i == A_CTRL)        ctrl_q <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
    end
  end

  alarm_match #(.NF(N_FLD)) u_alarm (
    .tick_i (tick_i),
    .alm_i  (alm_q),
    .time_i (time_vec),
    .evt_o  (al_evt)
  );

  wdt_timer #(.WDT_W(WDT_W)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .load_i   (wdt_load),
    .reload_i (reg_wdata_i[WDT_W-1:0]),
    .reload_o (wdt_reload),
    .expire_o (wd_evt)
  );

  assign pf_evt  = pwr_fail_i && !pf_q;
  assign evt_vec = {pf_evt, al_evt, wd_evt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      pf_q    <= pwr_fail_i;
      flags_q <= (rd_clr ? '0 : flags_q) | evt_vec;
    end
  end

  irq_gen #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags_q),
    .ctrl_i (ctrl_q),
    .trig_i (|(evt_vec & ctrl_q.ien)),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_ALM_SEC, A_ALM_MIN, A_ALM_HOUR, A_ALM_DATE: reg_rdata_o = alm_q[reg_addr_i[1:0]];
      A_CTRL:  reg_rdata_o = DATA_W'(ctrl_q);
      A_WDT:   reg_rdata_o = DATA_W'(wdt_reload);
      A_FLAGS: reg_rdata_o = DATA_W'(flags_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign flags_o       = flags_q;
  assign wdt_timeout_o = wd_evt;

  // R3
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && evt_vec == '0) |=> (flags_q == '0));
  // R4
  evt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && al_evt) |=> flags_q[F_AL]);
  // R5
  wdt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_o |=> flags_q[F_WD]);
  // R6
  pf_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && !pf_q) |=> flags_q[F_PF]);
endmodule

// File: tb/tb_rtc_event_irq.sv
module tb_rtc_event_irq;
  localparam int PL = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] sec, mn, hr, dt;
  logic tick = 0, pfail = 0, we = 0, re = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] flags;
  logic irq, wto;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  rtc_event_irq #(.WDT_W(6), .PULSE_LEN(PL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .min_i(mn), .hour_i(hr), .date_i(dt),
    .tick_i(tick), .pwr_fail_i(pfail), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .flags_o(flags), .irq_o(irq), .wdt_timeout_o(wto));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); re = 1; addr = a; #1 v = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic tk(output logic to);
    @(negedge clk); tick = 1; #1 to = wto;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic to;
    logic [7:0] av[4];
    int cnt;
    av[0] = 8'h12; av[1] = 8'h34; av[2] = 8'h05; av[3] = 8'h21;
    sec = 0; mn = 0; hr = 0; dt = 0;
    #12 rst_n = 1;
    // R1
    @(negedge clk);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 1);
    for (int a = 0; a < 6; a++) begin addr = 3'(a); #1 chk("R1 reg", rdata, 0); end
    begin
      int c = 0;
      repeat (3) begin tk(to); c += int'(to); end
      chk("R1 wdt off", {31'd0, flags[0]} + 32'(c), 0);
    end
    rd(3'd6, v);
    // R11
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R11 ctrl", v, 8'h1F);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R11 wdt", v, 8'h3F);
    wr(3'd5, 8'h00); wr(3'd4, 8'h00);
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), av[a] | 8'h80); rd(3'(a), v); chk("R11 alarm", v, av[a] | 8'h80);
    end
    // R2: every mask set against every field-agreement pattern
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 4; a++) wr(3'(a), av[a] | (m[a] ? 8'h80 : 8'h00));
      for (int p = 0; p < 16; p++) begin
        logic exp;
        sec = p[0] ? av[0] : av[0] ^ 8'h01;
        mn  = p[1] ? av[1] : av[1] ^ 8'h01;
        hr  = p[2] ? av[2] : av[2] ^ 8'h01;
        dt  = p[3] ? av[3] : av[3] ^ 8'h01;
        exp = (m[0] | p[0]) & (m[1] | p[1]) & (m[2] | p[2]) & (m[3] | p[3]);
        tk(to);
        chk("R2 alarm match", flags[1], exp);
        chk("R7 no enable", irq, 1);
        rd(3'd6, v);
        chk("R3 read value", v[1], exp);
        chk("R3 cleared", flags, 0);
      end
    end
    for (int a = 0; a < 4; a++) wr(3'(a), 8'h80);
    // R4 event with simultaneous read
    @(negedge clk); tick = 1; re = 1; addr = 3'd6;
    @(negedge clk); tick = 0; re = 0;
    chk("R4 kept", flags[1], 1);
    rd(3'd6, v);
    // R7/R10 level active-low
    tk(to); chk("R7 gated", irq, 1);
    wr(3'd4, 8'h02); chk("R7 enabled", irq, 0);
    repeat (5) @(negedge clk);
    chk("R10 level held", irq, 0);
    rd(3'd6, v); chk("R10 released", irq, 1);
    // R8 polarity
    wr(3'd4, 8'h0A); chk("R8 idle high-pol", irq, 0);
    tk(to); chk("R8 active high", irq, 1);
    rd(3'd6, v); chk("R8 released", irq, 0);
    // R9 pulse
    wr(3'd4, 8'h1A);
    tk(to);
    cnt = int'(irq);
    repeat (9) begin @(negedge clk); cnt += int'(irq); end
    chk("R9 pulse width", cnt, PL);
    chk("R9 flag still set", flags[1], 1);
    rd(3'd6, v);
    wr(3'd4, 8'h00);
    for (int a = 0; a < 4; a++) wr(3'(a), 8'h00);
    sec = 8'h59; mn = 8'h59; hr = 8'h23; dt = 8'h31;
    // R5 watchdog
    wr(3'd5, 8'd3);
    tk(to); chk("R5 t1", to, 0);
    tk(to); chk("R5 t2", to, 0);
    wr(3'd5, 8'd3);
    tk(to); tk(to); chk("R5 kicked", flags[0], 0);
    tk(to); chk("R5 expire strobe", to, 1);
    chk("R5 flag", flags[0], 1);
    rd(3'd6, v);
    tk(to); tk(to); chk("R5 rearm early", flags[0], 0);
    tk(to); chk("R5 rearm expire", to, 1);
    wr(3'd5, 8'd0);
    rd(3'd6, v);
    begin
      int c = 0;
      repeat (8) begin tk(to); c += int'(to); end
      chk("R5 disabled", c, 0);
      chk("R5 disabled flag", flags[0], 0);
    end
    // R6 power fail edge
    @(negedge clk); pfail = 1;
    @(negedge clk); chk("R6 set", flags[2], 1);
    rd(3'd6, v);
    repeat (3) @(negedge clk);
    chk("R6 level no reset", flags[2], 0);
    pfail = 0; repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule